// File: doc/BRIEF.md
# Real-Time Boost Converter Emulator

This block reproduces the behaviour of an ideal boost converter in real time. It keeps two state variables: the inductor current and the output capacitor voltage. Both are held as signed fixed-point numbers. On every emulation tick, marked by a one-cycle enable pulse, it advances both states by one forward-Euler step. The step uses the source voltage and the transistor gate command sampled in that cycle. The per-topology step coefficients (time step over inductance, time step over capacitance, time step over the load time constant) are parameters computed outside the block.

A switching engine chooses one of three usable circuit topologies at the start of each tick. It decides from the gate command and the state left by the previous tick. The diode is not commanded. It conducts while the inductor carries positive current with the transistor open. It also starts conducting when the source would push the switch node above the capacitor voltage. It stops, with the current clamped to zero, when a freewheeling step would drive the current negative. The states never jump when the topology changes; only the update equations differ. The block outputs both states and a two-bit topology code. A controller under test closes its loop on these outputs.

Top module: `boost_emu`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `il_o`, `vc_o` and `topo_o` are all zero.
- R2: In a cycle where `tick` is low, none of `il_o`, `vc_o` or `topo_o` changes, whatever `gate` and `src_v` do.
- R3: A tick with `gate` high selects topology code 2'b10 (bit 1 = transistor on, bit 0 = diode on). The current becomes `il + q(K_L, E)` and the voltage becomes `vc - q(K_RC, vc)`. Here q(k,x) = floor(k*x / 2^FRAC) and E = `src_v`.
- R4: A tick with `gate` low and a previous current above zero keeps the diode on (code 2'b01) in that same tick. The current becomes `il + q(K_L, E - vc)` and the voltage becomes `vc + q(K_C, il) - q(K_RC, vc)`. Both right-hand sides use the previous state.
- R5: A tick with `gate` low, a previous current of zero and E strictly above the previous `vc` turns the diode on (code 2'b01) and applies the update of R4.
- R6: A tick with `gate` low, a previous current of zero and E at or below the previous `vc` selects code 2'b00. The current stays zero and the voltage becomes `vc - q(K_RC, vc)`.
- R7: When the update of R4 would produce a negative current, that tick stores a current of exactly zero and reports code 2'b00 (diode now blocking).
- R8: `topo_o` never shows code 2'b11.
- R9: `il_o` is never negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Emulation step enable, one cycle per step |
| gate | input | 1 | Transistor command, 1 = conducting |
| src_v | input | W | Source voltage, signed, FRAC fraction bits |
| il_o | output | W | Inductor current state, signed, FRAC fraction bits |
| vc_o | output | W | Capacitor voltage state, signed, FRAC fraction bits |
| topo_o | output | 2 | Active topology code of the last tick: bit 1 transistor, bit 0 diode |

## Verification
The hardest situation to reach from the ports is the diode cut-off of R7. The current must be positive and the capacitor voltage above the source, so that a freewheeling step drives the current through zero. The stimulus gets there in steps. It first charges the inductor with the gate held high. It then releases the gate and lets the resulting resonance lift the capacitor well above the source. It keeps ticking until the bench's own model predicts a negative step. That tick must show a zero current and code 2'b00. After the cut-off, the bench raises the source above the stored voltage to make the diode turn on from rest (R5).

// File: rtl/boost_emu_pkg.sv
package boost_emu_pkg;

  // Topology code: bit 1 = transistor conducting, bit 0 = diode conducting.
  // Code 2'b11 is unreachable and has no name on purpose.
  typedef enum logic [1:0] {
    TOPO_IDLE   = 2'b00,
    TOPO_FREE   = 2'b01,
    TOPO_CHARGE = 2'b10
  } topo_e;

endpackage

// File: rtl/boost_switch_sel.sv
// Switching engine: picks the topology for this tick from the gate command
// and the state stored by the previous tick.
module boost_switch_sel
  import boost_emu_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                gate,
  input  logic signed [W-1:0] il,
  input  logic signed [W-1:0] vc,
  input  logic signed [W-1:0] e_src,
  output topo_e               topo,
  output logic                forced_on,
  output logic                diode_fire
);

  localparam int XW = W + 1;

  logic signed [XW-1:0] vd;

  always_comb begin
    // diode voltage with zero current: switch node sits at the source
    vd         = XW'(e_src) - XW'(vc);
    forced_on  = !gate && (il > 0);
    diode_fire = !gate && (il == 0) && (vd > 0);
    if (gate)
      topo = TOPO_CHARGE;
    else if (forced_on || diode_fire)
      topo = TOPO_FREE;
    else
      topo = TOPO_IDLE;
  end

endmodule

// File: rtl/boost_state_upd.sv
// One forward-Euler step of both states for the selected topology.
module boost_state_upd
  import boost_emu_pkg::*;
#(
  parameter int                W    = 24,
  parameter int                FRAC = 16,
  parameter logic signed [W-1:0] K_L  = W'(3277),
  parameter logic signed [W-1:0] K_C  = W'(1311),
  parameter logic signed [W-1:0] K_RC = W'(66)
) (
  input  topo_e               topo,
  input  logic signed [W-1:0] il,
  input  logic signed [W-1:0] vc,
  input  logic signed [W-1:0] e_src,
  output logic signed [W-1:0] il_nx,
  output logic signed [W-1:0] vc_nx,
  output logic                rev_cur
);

  localparam int XW = W + 1;
  localparam int PW = 2 * W + 1;
  localparam int SW = W + 2;

  // Fixed-point product with floor rounding: (k * x) >> FRAC
  function automatic logic signed [XW-1:0] mulq(
    input logic signed [W-1:0]  k,
    input logic signed [XW-1:0] x
  );
    logic signed [PW-1:0] p;
    p = PW'(k) * PW'(x);
    return p[FRAC +: XW];
  endfunction

  logic signed [XW-1:0] decay, charge, drv_on, drv_free;
  logic signed [SW-1:0] il_sum, vc_sum;

  always_comb begin
    decay    = mulq(K_RC, XW'(vc));
    charge   = mulq(K_C, XW'(il));
    drv_on   = mulq(K_L, XW'(e_src));
    drv_free = mulq(K_L, XW'(e_src) - XW'(vc));
    case (topo)
      TOPO_CHARGE: begin
        il_sum = SW'(il) + SW'(drv_on);
        vc_sum = SW'(vc) - SW'(decay);
      end
      TOPO_FREE: begin
        il_sum = SW'(il) + SW'(drv_free);
        vc_sum = SW'(vc) + SW'(charge) - SW'(decay);
      end
      default: begin
        il_sum = '0;
        vc_sum = SW'(vc) - SW'(decay);
      end
    endcase
    rev_cur = (il_sum < 0);
    il_nx   = rev_cur ? '0 : il_sum[W-1:0];
    vc_nx   = vc_sum[W-1:0];
  end

endmodule

// File: rtl/boost_emu.sv
module boost_emu
  import boost_emu_pkg::*;
#(
  parameter int                  W    = 24,
  parameter int                  FRAC = 16,
  parameter logic signed [W-1:0] K_L  = W'(3277),
  parameter logic signed [W-1:0] K_C  = W'(1311),
  parameter logic signed [W-1:0] K_RC = W'(66)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                gate,
  input  logic signed [W-1:0] src_v,
  output logic signed [W-1:0] il_o,
  output logic signed [W-1:0] vc_o,
  output logic [1:0]          topo_o
);

  logic signed [W-1:0] il_q, vc_q, il_nx, vc_nx;
  logic [1:0]          topo_q;
  topo_e               sel_topo;
  logic                forced_on, diode_fire, rev_cur;
  logic                diode_cut;

  boost_switch_sel #(.W(W)) u_sel (
    .gate       (gate),
    .il         (il_q),
    .vc         (vc_q),
    .e_src      (src_v),
    .topo       (sel_topo),
    .forced_on  (forced_on),
    .diode_fire (diode_fire)
  );

  boost_state_upd #(
    .W(W), .FRAC(FRAC), .K_L(K_L), .K_C(K_C), .K_RC(K_RC)
  ) u_upd (
    .topo    (sel_topo),
    .il      (il_q),
    .vc      (vc_q),
    .e_src   (src_v),
    .il_nx   (il_nx),
    .vc_nx   (vc_nx),
    .rev_cur (rev_cur)
  );

  // Event: a conducting diode turns off in this tick
  assign diode_cut = tick && rev_cur && (sel_topo == TOPO_FREE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      il_q   <= '0;
      vc_q   <= '0;
      topo_q <= TOPO_IDLE;
    end else if (tick) begin
      il_q   <= il_nx;
      vc_q   <= vc_nx;
      topo_q <= diode_cut ? TOPO_IDLE : sel_topo;
    end
  end

  assign il_o   = il_q;
  assign vc_o   = vc_q;
  assign topo_o = topo_q;

endmodule

// File: rtl/boost_emu_chk.sv
module boost_emu_chk #(
  parameter int W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                gate,
  input logic signed [W-1:0] src_v,
  input logic signed [W-1:0] il_o,
  input logic signed [W-1:0] vc_o,
  input logic [1:0]          topo_o,
  input logic                forced_on,
  input logic                diode_fire,
  input logic                diode_cut
);

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(il_o) && $stable(vc_o) && $stable(topo_o)));

  assert_gate_charge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gate) |=> (topo_o == 2'b10));

  assert_current_continuity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && forced_on) |=> ((topo_o == 2'b01) || (topo_o == 2'b00 && il_o == 0)));

  assert_diode_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && diode_fire) |=> (topo_o == 2'b01));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !gate && il_o == 0 && src_v <= vc_o) |=> (topo_o == 2'b00 && il_o == 0));

  assert_cut_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && diode_cut) |=> (il_o == 0 && topo_o == 2'b00));

  assert_no_unreachable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    topo_o != 2'b11);

  assert_current_nonneg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !il_o[W-1]);

endmodule

bind boost_emu boost_emu_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .gate       (gate),
  .src_v      (src_v),
  .il_o       (il_o),
  .vc_o       (vc_o),
  .topo_o     (topo_o),
  .forced_on  (forced_on),
  .diode_fire (diode_fire),
  .diode_cut  (diode_cut)
);

// File: tb/boost_emu_test.sv
`timescale 1ns/1ps
module boost_emu_test;

  localparam int     W    = 24;
  localparam int     FRAC = 16;
  localparam longint KL   = 3277;
  localparam longint KC   = 1311;
  localparam longint KRC  = 66;
  localparam longint ONE  = 65536;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic gate = 1'b0;
  logic signed [W-1:0] src_v = '0;
  logic signed [W-1:0] il_o, vc_o;
  logic [1:0] topo_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // bench model state
  longint m_il = 0, m_vc = 0;
  int     m_topo = 0;

  always #2.5 clk = ~clk;

  boost_emu #(
    .W(W), .FRAC(FRAC), .K_L(W'(KL)), .K_C(W'(KC)), .K_RC(W'(KRC))
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .src_v(src_v),
    .il_o(il_o), .vc_o(vc_o), .topo_o(topo_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  function automatic longint q(input longint k, input longint x);
    return (k * x) >>> FRAC;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Advance the model by one step; returns 1 when the diode is cut off.
  function automatic bit model_step(input bit g, input longint e);
    longint nil, nvc;
    bit cut = 0;
    if (g) begin
      m_topo = 2;
      nil = m_il + q(KL, e);
      nvc = m_vc - q(KRC, m_vc);
    end else if (m_il > 0 || e > m_vc) begin
      m_topo = 1;
      nil = m_il + q(KL, e - m_vc);
      nvc = m_vc + q(KC, m_il) - q(KRC, m_vc);
      if (nil < 0) begin
        nil = 0;
        m_topo = 0;
        cut = 1;
      end
    end else begin
      m_topo = 0;
      nil = 0;
      nvc = m_vc - q(KRC, m_vc);
    end
    m_il = nil;
    m_vc = nvc;
    return cut;
  endfunction

  task automatic step(input bit g, input longint e, input string tag, output bit cut);
    cut = model_step(g, e);
    gate  = g;
    src_v = W'(e);
    tick  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    chk({tag, " il"}, longint'(il_o), m_il);
    chk({tag, " vc"}, longint'(vc_o), m_vc);
    chk({tag, " topo"}, longint'(topo_o), longint'(m_topo));
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick  = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 il in reset", longint'(il_o), 0);
    chk("R1 vc in reset", longint'(vc_o), 0);
    chk("R1 topo in reset", longint'(topo_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 il after release", longint'(il_o), 0);
    chk("R1 vc after release", longint'(vc_o), 0);
    chk("R1 topo after release", longint'(topo_o), 0);
    m_il = 0; m_vc = 0; m_topo = 0;
  endtask

  task automatic t_charge();
    bit c;
    for (int i = 0; i < 40; i++) step(1'b1, 10 * ONE, "R3 charge", c);
    chk("R3 current grew", longint'(il_o > 0), 1);
  endtask

  task automatic t_freewheel_cut();
    bit c;
    bit seen = 0;
    bit first = 1;
    for (int i = 0; i < 400 && !seen; i++) begin
      step(1'b0, 10 * ONE, first ? "R4 forced on" : "R4 freewheel", c);
      if (first) chk("R4 diode on after gate fall", longint'(topo_o), 1);
      first = 0;
      if (c) begin
        seen = 1;
        chk("R7 cut current zero", longint'(il_o), 0);
        chk("R7 cut code idle", longint'(topo_o), 0);
      end
      chk("R8 no code 3", longint'(topo_o == 2'b11), 0);
      chk("R9 current non-negative", longint'(il_o < 0), 0);
    end
    chk("R7 cut reached", longint'(seen), 1);
    chk("R6 voltage above source", longint'(vc_o > 10 * ONE), 1);
  endtask

  task automatic t_idle();
    bit c;
    for (int i = 0; i < 20; i++) step(1'b0, 10 * ONE, "R6 idle decay", c);
    chk("R6 idle code", longint'(topo_o), 0);
    chk("R6 idle current", longint'(il_o), 0);
  endtask

  task automatic t_no_tick();
    logic signed [W-1:0] il_s, vc_s;
    logic [1:0] tp_s;
    il_s = il_o; vc_s = vc_o; tp_s = topo_o;
    for (int i = 0; i < 6; i++) begin
      gate  = i[0];
      src_v = W'(longint'(i) * 7 * ONE);
      @(negedge clk);
    end
    chk("R2 il held", longint'(il_o), longint'(il_s));
    chk("R2 vc held", longint'(vc_o), longint'(vc_s));
    chk("R2 topo held", longint'(topo_o), longint'(tp_s));
  endtask

  task automatic t_fire();
    bit c;
    longint e;
    e = m_vc + 14 * ONE;
    step(1'b0, e, "R5 diode fire", c);
    chk("R5 fire code", longint'(topo_o), 1);
    for (int i = 0; i < 8; i++) step(1'b0, e, "R5 conduct", c);
    for (int i = 0; i < 5; i++) step(1'b1, e, "R3 recharge", c);
    step(1'b0, e, "R4 forced on again", c);
    chk("R4 forced code", longint'(topo_o), 1);
  endtask

  initial begin
    t_reset();
    t_charge();
    t_freewheel_cut();
    t_idle();
    t_no_tick();
    t_fire();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule